// File: doc/BRIEF.md
# Indirect Control Status Register Unit

This block is the host-facing register file of a network controller. The host sees only two 16-bit locations. One is an address port that names an internal control/status register. The other is a data port that reads or writes the register named there. Register 0 is the mode and status word. It collects command bits, engine-state bits, latched event flags and the interrupt request. The other implemented registers hold configuration: the base address of the initialization block, the bus byte-order settings, a 64-bit multicast hash filter and a promiscuous-mode word.

Command bits are write-one-to-set and produce single-cycle strobes toward the transmit, receive and initialization engines, which sit outside this block. Event flags are set by input pulses from those engines and are write-one-to-clear. A stop command overrides every other bit of the same write. It also clears the byte-order configuration, so the host must program that configuration again after each stop. Configuration registers accept writes only while the controller is stopped.

Top module: `indirect_csr_unit`

## Requirements
- R1: A write with `host_sel`=1 stores `host_wdata[3:0]` as the selected register number, and a read with `host_sel`=1 returns that number. With `host_sel`=0, reads and writes act on the selected register. Numbers 4 to 7 and 12 to 14 read as zero and ignore writes.
- R2: After reset, register 0 reads 0x0004 (stop only). Every other register reads zero, and `irq` and all command strobes are low.
- R3: Writing register 0 with bit 2 (stop) set makes register 0 read exactly 0x0004 whatever else was written, clears register 3, and raises `cmd_stop` for one cycle.
- R4: Writing 1 to register 0 bit 0 (init) sets that bit and raises `cmd_init` for one cycle. A pulse on `init_done` sets bit 8 (init-done).
- R5: Writing 1 to register 0 bit 1 (start) sets it, clears bit 2, sets bit 4 (transmitter on) and bit 5 (receiver on), and raises `cmd_start` for one cycle.
- R6: Writing 1 to register 0 bit 3 (transmit demand) makes it read 1 in the following cycle, with `cmd_tx_demand` high, and 0 one cycle later.
- R7: Register 0 bit 6 (interrupt enable) takes the written value on every register 0 write without the stop bit.
- R8: Register 0 bits 8 to 14 (init-done, tx-done, rx-done, memory error, missed frame, carrier error, babble) are set by their input pulses and cleared by writing 1. Writing 0 leaves them unchanged, and an input pulse in the same cycle as a clearing write leaves the bit set.
- R9: Bit 15 reads as the OR of babble, carrier error, missed frame and memory error. Bit 7 reads as the OR of babble, missed frame, memory error, rx-done, tx-done and init-done.
- R10: `irq` is high exactly when register 0 bit 7 and bit 6 are both set.
- R11: While stopped, writes to registers 1 and 2 form `init_base` (low and high halves). Register 3 bits 2:0 drive `bus_cfg`. Registers 8 to 11 form `mcast_filter`, with register 8 as the least significant word. Register 15 is stored whole and its bit 15 drives `promisc`. While not stopped, writes to these registers are ignored.
- R12: Writes to register 0 bits 4, 5, 7 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 1 selects the address port, 0 the data port |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected port |
| init_done | input | 1 | Pulse: initialization block fetched |
| evt_tx_done | input | 1 | Pulse: transmit completed |
| evt_rx_done | input | 1 | Pulse: frame received |
| evt_mem_err | input | 1 | Pulse: memory access error |
| evt_missed | input | 1 | Pulse: receive frame missed |
| evt_no_carrier | input | 1 | Pulse: carrier check failed |
| evt_babble | input | 1 | Pulse: transmit too long |
| cmd_init | output | 1 | One-cycle initialization request |
| cmd_start | output | 1 | One-cycle start request |
| cmd_stop | output | 1 | One-cycle stop request |
| cmd_tx_demand | output | 1 | One-cycle transmit poll request |
| irq | output | 1 | Interrupt request, active high |
| init_base | output | 32 | Initialization block address |
| bus_cfg | output | 3 | Byte-order and bus control settings |
| mcast_filter | output | 64 | Multicast hash filter |
| promisc | output | 1 | Promiscuous mode enable |

## Verification
The assertions assume that event inputs are single-cycle pulses. They also assume that the host never writes the address port and the data port in the same cycle, because the single select line makes that impossible. The stimulus holds each event input high for exactly one clock and issues one host access per cycle. One case deliberately makes an event pulse coincide with a clearing write, to exercise the set-over-clear priority.

// File: rtl/indirect_csr_unit.sv
module indirect_csr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        init_done,
  input  logic        evt_tx_done,
  input  logic        evt_rx_done,
  input  logic        evt_mem_err,
  input  logic        evt_missed,
  input  logic        evt_no_carrier,
  input  logic        evt_babble,
  output logic        cmd_init,
  output logic        cmd_start,
  output logic        cmd_stop,
  output logic        cmd_tx_demand,
  output logic        irq,
  output logic [31:0] init_base,
  output logic [2:0]  bus_cfg,
  output logic [63:0] mcast_filter,
  output logic        promisc
);

  logic [3:0]  sel_q;
  logic        f_init, f_strt, f_stop, f_tdmd, f_txon, f_rxon, f_inea;
  logic [6:0]  st;
  logic [15:0] base_lo, base_hi, mode_q;
  logic [2:0]  cfg_q;
  logic [63:0] filt_q;

  logic        wr_data, wr0, stop_wr, cfg_wr, intr, err;
  logic [6:0]  ev;
  logic [15:0] csr0;

  assign wr_data = host_wr && !host_sel;
  assign wr0     = wr_data && (sel_q == 4'd0);
  assign stop_wr = wr0 && host_wdata[2];
  assign cfg_wr  = wr_data && f_stop;
  assign ev      = {evt_babble, evt_no_carrier, evt_missed, evt_mem_err,
                    evt_rx_done, evt_tx_done, init_done};

  assign intr = st[6] | st[4] | st[3] | st[2] | st[1] | st[0];
  assign err  = st[6] | st[5] | st[4] | st[3];
  assign csr0 = {err, st, intr, f_inea, f_rxon, f_txon, f_tdmd, f_stop, f_strt, f_init};

  assign irq           = intr && f_inea;
  assign cmd_tx_demand = f_tdmd;
  assign init_base     = {base_hi, base_lo};
  assign bus_cfg       = cfg_q;
  assign mcast_filter  = filt_q;
  assign promisc       = mode_q[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      f_init <= 1'b0; f_strt <= 1'b0; f_stop <= 1'b1; f_tdmd <= 1'b0;
      f_txon <= 1'b0; f_rxon <= 1'b0; f_inea <= 1'b0;
      st <= '0;
      base_lo <= '0; base_hi <= '0; mode_q <= '0; cfg_q <= '0; filt_q <= '0;
      cmd_init <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0;
    end else begin
      cmd_init  <= 1'b0;
      cmd_start <= 1'b0;
      cmd_stop  <= 1'b0;
      f_tdmd    <= 1'b0;
      if (host_wr && host_sel) sel_q <= host_wdata[3:0];
      if (stop_wr) begin
        f_stop <= 1'b1; f_init <= 1'b0; f_strt <= 1'b0;
        f_txon <= 1'b0; f_rxon <= 1'b0; f_inea <= 1'b0;
        st <= '0;
        cfg_q <= '0;
        cmd_stop <= 1'b1;
      end else begin
        st <= (st & ~(wr0 ? host_wdata[14:8] : 7'd0)) | ev;
        if (wr0) begin
          f_inea <= host_wdata[6];
          if (host_wdata[0]) begin
            f_init   <= 1'b1;
            cmd_init <= 1'b1;
          end
          if (host_wdata[1]) begin
            f_strt <= 1'b1; f_stop <= 1'b0;
            f_txon <= 1'b1; f_rxon <= 1'b1;
            cmd_start <= 1'b1;
          end
          if (host_wdata[3]) f_tdmd <= 1'b1;
        end
        if (cfg_wr) begin
          case (sel_q)
            4'd1:  base_lo <= host_wdata;
            4'd2:  base_hi <= host_wdata;
            4'd3:  cfg_q <= host_wdata[2:0];
            4'd8:  filt_q[15:0]  <= host_wdata;
            4'd9:  filt_q[31:16] <= host_wdata;
            4'd10: filt_q[47:32] <= host_wdata;
            4'd11: filt_q[63:48] <= host_wdata;
            4'd15: mode_q <= host_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (host_sel) host_rdata = {12'd0, sel_q};
    else begin
      case (sel_q)
        4'd0:  host_rdata = csr0;
        4'd1:  host_rdata = base_lo;
        4'd2:  host_rdata = base_hi;
        4'd3:  host_rdata = {13'd0, cfg_q};
        4'd8:  host_rdata = filt_q[15:0];
        4'd9:  host_rdata = filt_q[31:16];
        4'd10: host_rdata = filt_q[47:32];
        4'd11: host_rdata = filt_q[63:48];
        4'd15: host_rdata = mode_q;
        default: host_rdata = 16'd0;
      endcase
    end
  end

  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (f_stop && !f_init && !f_strt && !f_txon && !f_inea && st == 7'd0
                 && cfg_q == 3'd0 && cmd_stop && !cmd_init));

  p_init_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && host_wdata[0] && !host_wdata[2]) |=> (cmd_init && f_init));

  p_idon_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !stop_wr) |=> st[0]);

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && host_wdata[1] && !host_wdata[2]) |=> (!f_stop && f_txon && f_rxon && cmd_start));

  p_tdmd_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (f_tdmd && !(wr0 && host_wdata[3])) |=> !f_tdmd);

  p_irq_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> f_inea);

  p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !f_stop |=> ($stable(base_lo) && $stable(base_hi) && $stable(filt_q) && $stable(mode_q)));

endmodule

// File: tb/tb_indirect_csr_unit.sv
module tb_indirect_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  // {sel, wdata, expected data-port read afterwards}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h0001, 16'h0000},
    {1'b0, 16'h1234, 16'h1234},
    {1'b1, 16'h0002, 16'h0000},
    {1'b0, 16'h00AB, 16'h00AB},
    {1'b1, 16'h0003, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0007},
    {1'b1, 16'h000F, 16'h0000},
    {1'b0, 16'h8001, 16'h8001},
    {1'b1, 16'h0009, 16'h0000},
    {1'b0, 16'hBEEF, 16'hBEEF},
    {1'b1, 16'h0005, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0000},
    {1'b1, 16'h0000, 16'h0004},
    {1'b0, 16'h0040, 16'h0044},
    {1'b0, 16'h0042, 16'h0072},
    {1'b0, 16'h80F0, 16'h0072},
    {1'b1, 16'h0003, 16'h0007},
    {1'b0, 16'h0000, 16'h0007},
    {1'b1, 16'h0001, 16'h1234},
    {1'b0, 16'h5555, 16'h1234},
    {1'b1, 16'h0000, 16'h0072},
    {1'b0, 16'h0004, 16'h0004},
    {1'b1, 16'h0003, 16'h0000},
    {1'b1, 16'h0000, 16'h0004}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic init_done = 0, evt_tx_done = 0, evt_rx_done = 0, evt_mem_err = 0;
  logic evt_missed = 0, evt_no_carrier = 0, evt_babble = 0;
  logic cmd_init, cmd_start, cmd_stop, cmd_tx_demand, irq, promisc;
  logic [31:0] init_base;
  logic [2:0]  bus_cfg;
  logic [63:0] mcast_filter;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  indirect_csr_unit dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .init_done(init_done),
    .evt_tx_done(evt_tx_done), .evt_rx_done(evt_rx_done), .evt_mem_err(evt_mem_err),
    .evt_missed(evt_missed), .evt_no_carrier(evt_no_carrier), .evt_babble(evt_babble),
    .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_tx_demand(cmd_tx_demand), .irq(irq), .init_base(init_base),
    .bus_cfg(bus_cfg), .mcast_filter(mcast_filter), .promisc(promisc));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0; host_sel = 1'b0;
    #1;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 csr0 reset", host_rdata, 16'h0004);
    check("R2 irq/strobes", {irq, cmd_init, cmd_start, cmd_stop, cmd_tx_demand}, 0);
    check("R2 cfg outputs", {init_base, bus_cfg, promisc}, 0);
    check("R2 filter", mcast_filter, 0);

    // R1 R11 R12 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][32], VEC[i][31:16]);
      check($sformatf("R1/R11/R12 vector %0d", i), host_rdata, VEC[i][15:0]);
    end
    check("R11 init_base", init_base, 32'h00AB1234);
    check("R11 mcast_filter", mcast_filter, 64'h0000_0000_BEEF_0000);
    check("R11 promisc", promisc, 1'b1);
    check("R3 bus_cfg cleared", bus_cfg, 3'd0);

    wr(1'b1, 16'h000B);
    host_sel = 1'b1; #1;
    check("R1 address read", host_rdata, 16'h000B);
    host_sel = 1'b0;
    wr(1'b1, 16'h0000);

    wr(1'b0, 16'h0001);
    check("R4 init bit", host_rdata, 16'h0005);
    check("R4 cmd_init pulse", cmd_init, 1'b1);
    step();
    check("R4 cmd_init drops", cmd_init, 1'b0);

    init_done = 1'b1; @(posedge clk); @(negedge clk); init_done = 1'b0; #1;
    check("R4 R9 idon and intr", host_rdata, 16'h0185);
    check("R10 irq masked", irq, 1'b0);

    wr(1'b0, 16'h0041);
    check("R7 inea set", host_rdata, 16'h01C5);
    check("R10 irq raised", irq, 1'b1);

    wr(1'b0, 16'h0140);
    check("R8 clear idon", host_rdata, 16'h0045);
    check("R10 irq cleared", irq, 1'b0);

    evt_no_carrier = 1'b1; @(posedge clk); @(negedge clk); evt_no_carrier = 1'b0; #1;
    check("R9 cerr err only", host_rdata, 16'hA045);
    check("R10 cerr no irq", irq, 1'b0);

    evt_babble = 1'b1; @(posedge clk); @(negedge clk); evt_babble = 1'b0; #1;
    check("R9 babble", host_rdata, 16'hE0C5);
    check("R10 babble irq", irq, 1'b1);

    wr(1'b0, 16'h0040);
    check("R8 write zero keeps", host_rdata, 16'hE0C5);

    evt_tx_done = 1'b1;
    wr(1'b0, 16'h0240);
    evt_tx_done = 1'b0;
    check("R8 set beats clear", host_rdata, 16'hE2C5);

    wr(1'b0, 16'h6240);
    check("R8 multi clear", host_rdata, 16'h0045);

    wr(1'b0, 16'h0042);
    check("R5 start", host_rdata, 16'h0073);
    check("R5 cmd_start", cmd_start, 1'b1);

    wr(1'b0, 16'h0048);
    check("R6 tdmd visible", host_rdata, 16'h007B);
    check("R6 cmd_tx_demand", cmd_tx_demand, 1'b1);
    step();
    check("R6 tdmd self clear", host_rdata, 16'h0073);
    check("R6 strobe drops", cmd_tx_demand, 1'b0);

    evt_missed = 1'b1; @(posedge clk); @(negedge clk); evt_missed = 1'b0; #1;
    check("R9 missed", host_rdata, 16'h90F3);

    wr(1'b0, 16'h0005);
    check("R3 stop wins", host_rdata, 16'h0004);
    check("R3 cmd_stop only", {cmd_stop, cmd_init, irq}, 3'b100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule